// File: doc/BRIEF.md
# JTAG Debug Transport to Register Bus Bridge

This block lets an external debugger reach a debug register bus through a standard four-wire JTAG port. A 16-state TAP controller steers scans into a 5-bit instruction register or into one of four data chains. These are a fixed identification word, a control/status word, a bus-access word, and a 1-bit bypass for every other instruction. A scan of the bus-access word carries an address, 32 bits of data and a 2-bit operation. When the scan completes, the block issues a read, or a read with a write of new data, on the register-bus request port. The next scan of the same word returns the read data with a 2-bit status.

The JTAG pins are oversampled by the system clock `clk` through a synchronizer of `SYNC_STAGES` flops, so all logic, including the bus side, sits in one clock domain. TCK must stay at each level for at least `SYNC_STAGES + 2` clock cycles. The bus request is held until the responder answers with `dmi_ready`, which may take any number of cycles. A debugger that scans too early is told so with a sticky busy status, and it clears that status through the control word.

Top module: `jdtm_top`

## Requirements
- R1: Reset low, trst_n low, or five TCK rising edges with TMS high from any TAP state place the TAP in Test-Logic-Reset, and that state selects the identification instruction (code 0x01). All other moves follow the standard 16-state TAP transition table.
- R2: The instruction register is 5 bits wide. Capture-IR loads the pattern 0b00001, so a scan shifts out 1 followed by four 0s. Update-IR adopts the value shifted in.
- R3: With instruction 0x01 the data chain is 32 bits long and captures ID_VALUE (default 0x1A3C5E01). Scans run LSB first: TDO shows bit 0, and each shift moves TDI into the top bit of the chain length.
- R4: With instruction 0x10 a 32-bit control word is captured. Its fields are: bits 3:0 = 1, bits 9:4 = ABITS, bits 11:10 = sticky status (0 clear, 3 busy), bits 14:12 = IDLE_HINT, and all other bits 0. The default when clear is 0x00003061.
- R5: Every instruction other than 0x01, 0x10 and 0x11 selects a 1-bit bypass chain that captures 0. TDO therefore shows 0 and then TDI delayed by one shift.
- R6: With instruction 0x11 the chain is ABITS+34 bits: op/status in bits 1:0, data in bits 33:2, address in bits ABITS+33:34. On Update-DR, op 1 issues one bus request with dmi_op=1 at that address. The next capture returns that address, the returned read data and status 0.
- R7: On Update-DR, op 2 issues one bus request with dmi_op=2 that carries the shifted data as write data. The next capture returns the read data (the value before the write) with status 0.
- R8: Op 0 and op 3 issue no bus request. The next capture returns the shifted address and data with status 0.
- R9: A capture of the bus-access word while a request is outstanding returns status 3 and sets a sticky busy flag. While the flag is set, captures return status 3, and an Update-DR of the bus-access word neither issues a request nor changes the stored address and data.
- R10: An Update-DR of the control word with bit 16 = 1 clears the sticky busy flag.
- R11: TDO changes only after a TCK falling edge, and it is 0 whenever the TAP is outside Shift-IR and Shift-DR.
- R12: dmi_valid is low after reset. Once raised, it stays high with address, write data and op stable until the cycle with dmi_ready high, which completes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the JTAG pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| tck | input | 1 | JTAG test clock, oversampled |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| trst_n | input | 1 | Active-low TAP reset; tie high if unused |
| tdo | output | 1 | JTAG serial data out |
| dmi_valid | output | 1 | Bus request pending |
| dmi_addr | output | ABITS | Request address |
| dmi_wdata | output | 32 | Request write data |
| dmi_op | output | 2 | Request operation: 1 read, 2 read then write |
| dmi_ready | input | 1 | Responder completes the pending request |
| dmi_rdata | input | 32 | Read data, valid with dmi_ready |

## Verification
The bus-access word is scanned with a read, a read-then-write, a no-op and the reserved op. The stored address and data are changed between scans, so a capture that returns stale fields, or wrongly issues or suppresses a request, shows up as a mismatch. The bypass and identification chains are scanned with patterns whose bits differ at each position, which separates a wrong chain length from a wrong bit order. A slow responder forces a scan during an outstanding request, and that case tells apart the transient busy status, the sticky busy status and the clearing of the flag through the control word. TAP reset is reached by the pin, by five TMS-high edges taken from inside a data shift, and by the power-on reset.

// File: rtl/jdtm_pkg.sv
`timescale 1ns/1ps
package jdtm_pkg;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_CTL, SEL_BUS} dr_sel_e;

  localparam logic [1:0] OPC_NOP  = 2'd0;
  localparam logic [1:0] OPC_RD   = 2'd1;
  localparam logic [1:0] OPC_RDWR = 2'd2;
  localparam logic [1:0] STS_OK   = 2'd0;
  localparam logic [1:0] STS_BUSY = 2'd3;

  localparam logic [7:0] INSN_ID  = 8'h01;
  localparam logic [7:0] INSN_CTL = 8'h10;
  localparam logic [7:0] INSN_BUS = 8'h11;

  // Next TAP state for a given TMS value.
  function automatic tap_state_e tap_step(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
      default:   n = m ? TS_SEL_DR : TS_IDLE;
    endcase
    return n;
  endfunction

  // Data chain selected by an instruction code.
  function automatic dr_sel_e insn_decode(logic [7:0] code);
    case (code)
      INSN_ID:  return SEL_ID;
      INSN_CTL: return SEL_CTL;
      INSN_BUS: return SEL_BUS;
      default:  return SEL_BYP;
    endcase
  endfunction

  // Control/status word assembly.
  function automatic logic [31:0] ctl_word(int abits, int idle, logic [1:0] st);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'd1;
    w[9:4]   = 6'(abits);
    w[11:10] = st;
    w[14:12] = 3'(idle);
    return w;
  endfunction

endpackage

// File: rtl/jdtm_sync.sv
`timescale 1ns/1ps
module jdtm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck,
  input  logic tms,
  input  logic tdi,
  output logic tck_rise,
  output logic tck_fall,
  output logic tms_s,
  output logic tdi_s
);
  // {tck, tms, tdi} moved together so TMS/TDI line up with the TCK edge
  logic [2:0] pipe_q [STAGES];
  logic       tck_last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= 3'b000;
      tck_last_q <= 1'b0;
    end else begin
      pipe_q[0] <= {tck, tms, tdi};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      tck_last_q <= pipe_q[STAGES-1][2];
    end
  end

  assign tck_rise = pipe_q[STAGES-1][2] & ~tck_last_q;
  assign tck_fall = ~pipe_q[STAGES-1][2] & tck_last_q;
  assign tms_s    = pipe_q[STAGES-1][1];
  assign tdi_s    = pipe_q[STAGES-1][0];
endmodule

// File: rtl/jdtm_tap.sv
`timescale 1ns/1ps
module jdtm_tap import jdtm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic trst_n,
  input  logic tck_rise,
  input  logic tms_s,
  output logic ev_cap_ir,
  output logic ev_sh_ir,
  output logic ev_upd_ir,
  output logic ev_cap_dr,
  output logic ev_sh_dr,
  output logic ev_upd_dr,
  output logic in_reset,
  output logic in_shift
);
  tap_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= TS_RESET;
    else if (!trst_n)  state_q <= TS_RESET;
    else if (tck_rise) state_q <= tap_step(state_q, tms_s);
  end

  // Actions take place on the TCK rising edge that leaves the state
  assign ev_cap_ir = tck_rise && (state_q == TS_CAP_IR);
  assign ev_sh_ir  = tck_rise && (state_q == TS_SH_IR);
  assign ev_upd_ir = tck_rise && (state_q == TS_UPD_IR);
  assign ev_cap_dr = tck_rise && (state_q == TS_CAP_DR);
  assign ev_sh_dr  = tck_rise && (state_q == TS_SH_DR);
  assign ev_upd_dr = tck_rise && (state_q == TS_UPD_DR);
  assign in_reset  = (state_q == TS_RESET);
  assign in_shift  = (state_q == TS_SH_DR) || (state_q == TS_SH_IR);

  // R1: the reset pin forces Test-Logic-Reset
  a_r1_trst_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !trst_n |=> (state_q == TS_RESET));

  // R1: update states always lead back to idle or select-DR
  a_r1_update_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (trst_n && (ev_upd_dr || ev_upd_ir)) |=> (state_q == TS_IDLE || state_q == TS_SEL_DR));
endmodule

// File: rtl/jdtm_bus.sv
`timescale 1ns/1ps
module jdtm_bus import jdtm_pkg::*; #(
  parameter int ABITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_bus,
  input  logic             upd_bus,
  input  logic             upd_ctl,
  input  logic             clr_req,
  input  logic [ABITS+33:0] shin,
  output logic [ABITS+33:0] bus_cap,
  output logic [1:0]       sticky_st,
  output logic             dmi_valid,
  output logic [ABITS-1:0] dmi_addr,
  output logic [31:0]      dmi_wdata,
  output logic [1:0]       dmi_op,
  input  logic             dmi_ready,
  input  logic [31:0]      dmi_rdata
);
  localparam int BUS_W = ABITS + 34;

  function automatic logic [1:0] fld_op(logic [BUS_W-1:0] w);
    return w[1:0];
  endfunction
  function automatic logic [31:0] fld_data(logic [BUS_W-1:0] w);
    return w[33:2];
  endfunction
  function automatic logic [ABITS-1:0] fld_addr(logic [BUS_W-1:0] w);
    return w[BUS_W-1:34];
  endfunction

  logic             sticky_q;
  logic [ABITS-1:0] last_addr_q;
  logic [31:0]      last_data_q;

  logic blocked, req_take, launch, rsp_done;
  assign blocked  = dmi_valid || sticky_q;
  assign req_take = upd_bus && !blocked;
  assign launch   = req_take && (fld_op(shin) == OPC_RD || fld_op(shin) == OPC_RDWR);
  assign rsp_done = dmi_valid && dmi_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmi_valid   <= 1'b0;
      dmi_addr    <= '0;
      dmi_wdata   <= '0;
      dmi_op      <= OPC_NOP;
      sticky_q    <= 1'b0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else begin
      if (rsp_done) begin
        dmi_valid   <= 1'b0;
        last_data_q <= dmi_rdata;
      end
      if (cap_bus && blocked)     sticky_q <= 1'b1;
      else if (upd_ctl && clr_req) sticky_q <= 1'b0;
      if (req_take) begin
        last_addr_q <= fld_addr(shin);
        last_data_q <= fld_data(shin);
      end
      if (launch) begin
        dmi_valid <= 1'b1;
        dmi_addr  <= fld_addr(shin);
        dmi_wdata <= fld_data(shin);
        dmi_op    <= fld_op(shin);
      end
    end
  end

  assign bus_cap   = {last_addr_q, last_data_q, blocked ? STS_BUSY : STS_OK};
  assign sticky_st = sticky_q ? STS_BUSY : STS_OK;

  // R12: a pending request is held stable until accepted
  a_r12_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (dmi_valid && !dmi_ready) |=> (dmi_valid && $stable(dmi_addr) && $stable(dmi_wdata) && $stable(dmi_op)));

  // R6 / R7: only read or read-then-write ever reach the bus
  a_r6_op_legal: assert property (@(posedge clk) disable iff (!rst_n)
    dmi_valid |-> (dmi_op == OPC_RD || dmi_op == OPC_RDWR));

  // R9: an early capture makes the busy flag sticky
  a_r9_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_bus && dmi_valid) |=> (sticky_st == STS_BUSY));

  // R9: an update while sticky busy issues nothing
  a_r9_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_bus && sticky_q) |=> !$rose(dmi_valid));
endmodule

// File: rtl/jdtm_top.sv
`timescale 1ns/1ps
module jdtm_top import jdtm_pkg::*; #(
  parameter int          ABITS       = 6,
  parameter int          IR_W        = 5,
  parameter logic [31:0] ID_VALUE    = 32'h1A3C_5E01,
  parameter int          IDLE_HINT   = 3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck,
  input  logic             tms,
  input  logic             tdi,
  input  logic             trst_n,
  output logic             tdo,
  output logic             dmi_valid,
  output logic [ABITS-1:0] dmi_addr,
  output logic [31:0]      dmi_wdata,
  output logic [1:0]       dmi_op,
  input  logic             dmi_ready,
  input  logic [31:0]      dmi_rdata
);
  localparam int BUS_W   = ABITS + 34;
  localparam int CHAIN_W = BUS_W;
  localparam int CLR_BIT = 16;
  localparam logic [IR_W-1:0] IR_DEFAULT = IR_W'(INSN_ID);
  localparam logic [IR_W-1:0] IR_CAPTURE = IR_W'(2'b01);

  // Shift right by one, TDI into bit len-1, bits above len cleared
  function automatic logic [CHAIN_W-1:0] shift_in(logic [CHAIN_W-1:0] c, int len, logic b);
    logic [CHAIN_W-1:0] r;
    r = c >> 1;
    for (int i = 0; i < CHAIN_W; i++) begin
      if (i == len - 1)   r[i] = b;
      else if (i >= len)  r[i] = 1'b0;
    end
    return r;
  endfunction

  logic tck_rise, tck_fall, tms_s, tdi_s;
  jdtm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .tck_rise(tck_rise), .tck_fall(tck_fall), .tms_s(tms_s), .tdi_s(tdi_s)
  );

  logic ev_cap_ir, ev_sh_ir, ev_upd_ir, ev_cap_dr, ev_sh_dr, ev_upd_dr, in_reset, in_shift;
  jdtm_tap u_tap (
    .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .tck_rise(tck_rise), .tms_s(tms_s),
    .ev_cap_ir(ev_cap_ir), .ev_sh_ir(ev_sh_ir), .ev_upd_ir(ev_upd_ir),
    .ev_cap_dr(ev_cap_dr), .ev_sh_dr(ev_sh_dr), .ev_upd_dr(ev_upd_dr),
    .in_reset(in_reset), .in_shift(in_shift)
  );

  logic [IR_W-1:0]    ir_q;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] cap_val;
  dr_sel_e            sel;
  int                 dr_len;

  assign sel = insn_decode(8'(ir_q));

  logic cap_bus, upd_bus, upd_ctl, clr_req;
  assign cap_bus = ev_cap_dr && (sel == SEL_BUS);
  assign upd_bus = ev_upd_dr && (sel == SEL_BUS);
  assign upd_ctl = ev_upd_dr && (sel == SEL_CTL);
  assign clr_req = chain_q[CLR_BIT];

  logic [BUS_W-1:0] bus_cap;
  logic [1:0]       sticky_st;
  jdtm_bus #(.ABITS(ABITS)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .cap_bus(cap_bus), .upd_bus(upd_bus), .upd_ctl(upd_ctl), .clr_req(clr_req),
    .shin(chain_q[BUS_W-1:0]), .bus_cap(bus_cap), .sticky_st(sticky_st),
    .dmi_valid(dmi_valid), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_op(dmi_op),
    .dmi_ready(dmi_ready), .dmi_rdata(dmi_rdata)
  );

  always_comb begin
    case (sel)
      SEL_ID:  begin cap_val = CHAIN_W'(ID_VALUE); dr_len = 32; end
      SEL_CTL: begin cap_val = CHAIN_W'(ctl_word(ABITS, IDLE_HINT, sticky_st)); dr_len = 32; end
      SEL_BUS: begin cap_val = CHAIN_W'(bus_cap); dr_len = BUS_W; end
      default: begin cap_val = '0; dr_len = 1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir_q <= IR_DEFAULT;
    else if (in_reset)  ir_q <= IR_DEFAULT;
    else if (ev_upd_ir) ir_q <= chain_q[IR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         chain_q <= '0;
    else if (ev_cap_ir) chain_q <= CHAIN_W'(IR_CAPTURE);
    else if (ev_cap_dr) chain_q <= cap_val;
    else if (ev_sh_ir)  chain_q <= shift_in(chain_q, IR_W, tdi_s);
    else if (ev_sh_dr)  chain_q <= shift_in(chain_q, dr_len, tdi_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tdo <= 1'b0;
    else if (tck_fall) tdo <= in_shift ? chain_q[0] : 1'b0;
  end

  // R1: Test-Logic-Reset selects the identification instruction
  a_r1_ir_default: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> (ir_q == IR_DEFAULT));

  // R2: instruction capture leaves the 01 pattern in the low bits
  a_r2_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cap_ir |=> (chain_q[1:0] == 2'b01));

  // R11: TDO quiet outside the shift states
  a_r11_tdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (tck_fall && !in_shift) |=> !tdo);

  // R11: TDO moves only on a falling TCK edge
  a_r11_tdo_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !tck_fall |=> $stable(tdo));
endmodule

// File: tb/test_jdtm_top.sv
`timescale 1ns/1ps
module test_jdtm_top;
  localparam int          ABITS  = 6;
  localparam int          HALF   = 6;
  localparam logic [31:0] ID_EXP = 32'h1A3C_5E01;
  localparam logic [31:0] CTL_EXP = 32'h0000_3061;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0, trst_n = 1'b1;
  logic tdo;
  logic dmi_valid, dmi_ready = 1'b0;
  logic [ABITS-1:0] dmi_addr;
  logic [31:0] dmi_wdata, dmi_rdata = 32'h0;
  logic [1:0] dmi_op;

  always #4 clk = ~clk;

  jdtm_top i_jdtm_top (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n), .tdo(tdo),
    .dmi_valid(dmi_valid), .dmi_addr(dmi_addr), .dmi_wdata(dmi_wdata), .dmi_op(dmi_op),
    .dmi_ready(dmi_ready), .dmi_rdata(dmi_rdata)
  );

  int checks = 0;
  int errors = 0;
  int dm_delay = 2;
  logic exit_tdo;

  typedef struct packed {
    logic [1:0]       op;
    logic [ABITS-1:0] addr;
    logic [31:0]      wdata;
  } txn_t;
  txn_t exp_q[$];

  function automatic logic [31:0] rd_model(logic [ABITS-1:0] a);
    return 32'hBEEF_0000 ^ ({26'b0, a} * 32'h0101_0101);
  endfunction

  function automatic logic [63:0] mk_bus(logic [ABITS-1:0] a, logic [31:0] d, logic [1:0] op);
    return 64'({a, d, op});
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Bus responder and scoreboard monitor
  always begin
    @(negedge clk);
    dmi_ready = 1'b0;
    if (dmi_valid) begin
      repeat (dm_delay) @(negedge clk);
      dmi_rdata = rd_model(dmi_addr);
      dmi_ready = 1'b1;
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8/R9 unexpected request: actual op %0d addr %h expected none", dmi_op, dmi_addr);
      end else begin
        txn_t e;
        e = exp_q.pop_front();
        chk("R6/R7 bus request", 64'({dmi_op, dmi_addr, dmi_wdata}), 64'(e));
      end
      @(negedge clk);
      dmi_ready = 1'b0;
    end
  end

  task automatic tclk(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    repeat (HALF) @(negedge clk);
    o = tdo;
    tck = 1'b1;
    repeat (HALF) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic goto_idle();
    logic o;
    for (int i = 0; i < 5; i++) tclk(1'b1, 1'b0, o);
    tclk(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [4:0] v, output logic [4:0] out);
    logic o;
    tclk(1'b1, 1'b0, o); tclk(1'b1, 1'b0, o); tclk(1'b0, 1'b0, o); tclk(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) begin
      tclk(i == 4, v[i], o);
      out[i] = o;
    end
    tclk(1'b1, 1'b0, o); exit_tdo = o;
    tclk(1'b0, 1'b0, o);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] v, output logic [63:0] out);
    logic o;
    out = '0;
    tclk(1'b1, 1'b0, o); tclk(1'b0, 1'b0, o); tclk(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      tclk(i == n - 1, v[i], o);
      out[i] = o;
    end
    tclk(1'b1, 1'b0, o); exit_tdo = o;
    tclk(1'b0, 1'b0, o);
  endtask

  task automatic bus_scan(input logic [ABITS-1:0] a, input logic [31:0] d, input logic [1:0] op,
                          input logic expect_req, output logic [63:0] out);
    if (expect_req) exp_q.push_back({op, a, d});
    scan_dr(ABITS + 34, mk_bus(a, d, op), out);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [4:0]  irv;
    logic [63:0] dv;
    logic        o;

    repeat (10) @(negedge clk);
    chk("R11 tdo in reset", 64'(tdo), 64'd0);
    chk("R12 dmi_valid in reset", 64'(dmi_valid), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    goto_idle();

    // R1 / R3: identification selected after reset, LSB first
    scan_dr(32, 64'h0, dv);
    chk("R3 idcode after reset (R1)", dv, 64'(ID_EXP));
    chk("R11 tdo in Exit1-DR", 64'(exit_tdo), 64'd0);

    // R2 / R4
    scan_ir(5'h10, irv);
    chk("R2 IR capture pattern", 64'(irv), 64'h01);
    chk("R11 tdo in Exit1-IR", 64'(exit_tdo), 64'd0);
    scan_dr(32, 64'h0, dv);
    chk("R4 control word", dv, 64'(CTL_EXP));

    // R5: bypass with two codes and two patterns
    scan_ir(5'h1F, irv);
    scan_dr(8, 64'hA6, dv);
    chk("R5 bypass 0x1F", dv, 64'({7'h26, 1'b0}));
    scan_ir(5'h02, irv);
    scan_dr(8, 64'h5B, dv);
    chk("R5 bypass 0x02", dv, 64'({7'h5B, 1'b0}));

    // R6 / R7 / R8
    scan_ir(5'h11, irv);
    bus_scan(6'h15, 32'h0000_0000, 2'd1, 1'b1, dv);
    bus_scan(6'h2A, 32'h1357_9BDF, 2'd0, 1'b0, dv);
    chk("R6 read result", dv, mk_bus(6'h15, rd_model(6'h15), 2'd0));
    bus_scan(6'h07, 32'hCAFE_F00D, 2'd2, 1'b1, dv);
    chk("R8 nop stores shifted fields", dv, mk_bus(6'h2A, 32'h1357_9BDF, 2'd0));
    bus_scan(6'h3F, 32'h0F0F_1234, 2'd3, 1'b0, dv);
    chk("R7 read-write returns old data", dv, mk_bus(6'h07, rd_model(6'h07), 2'd0));
    bus_scan(6'h01, 32'h0, 2'd0, 1'b0, dv);
    chk("R8 reserved op stores shifted fields", dv, mk_bus(6'h3F, 32'h0F0F_1234, 2'd0));

    // R9 / R10: slow responder
    dm_delay = 3000;
    bus_scan(6'h11, 32'h0, 2'd1, 1'b1, dv);
    bus_scan(6'h22, 32'hDEAD_BEEF, 2'd2, 1'b0, dv);
    chk("R9 busy status while pending", 64'(dv[1:0]), 64'd3);
    wait (!dmi_valid);
    repeat (10) @(negedge clk);
    bus_scan(6'h33, 32'h0, 2'd1, 1'b0, dv);
    chk("R9 busy status is sticky", 64'(dv[1:0]), 64'd3);
    scan_ir(5'h10, irv);
    scan_dr(32, 64'h0, dv);
    chk("R9 control status busy", 64'(dv[11:10]), 64'd3);
    scan_dr(32, 64'h0001_0000, dv);
    scan_dr(32, 64'h0, dv);
    chk("R10 busy cleared", dv, 64'(CTL_EXP));
    scan_ir(5'h11, irv);
    bus_scan(6'h05, 32'h0, 2'd0, 1'b0, dv);
    chk("R9 busy updates ignored (R10 status clear)", dv, mk_bus(6'h11, rd_model(6'h11), 2'd0));
    dm_delay = 2;

    // R1: reset pin
    scan_ir(5'h10, irv);
    @(negedge clk); trst_n = 1'b0;
    repeat (4) @(negedge clk); trst_n = 1'b1;
    tclk(1'b0, 1'b0, o);
    scan_dr(32, 64'h0, dv);
    chk("R1 trst selects idcode", dv, 64'(ID_EXP));

    // R1: five TMS-high edges from inside Shift-DR
    scan_ir(5'h10, irv);
    tclk(1'b1, 1'b0, o); tclk(1'b0, 1'b0, o); tclk(1'b0, 1'b0, o);
    for (int i = 0; i < 3; i++) tclk(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) tclk(1'b1, 1'b0, o);
    tclk(1'b0, 1'b0, o);
    scan_dr(32, 64'h0, dv);
    chk("R1 five TMS-high edges reset", dv, 64'(ID_EXP));

    repeat (20) @(negedge clk);
    chk("R6/R7 all expected requests issued", 64'(exp_q.size()), 64'd0);
    report();
  end
endmodule